// File: doc/BRIEF.md
# Lazy Condition Code Evaluator

This block rebuilds the four processor status flags (negative, zero, overflow, carry) long after the instruction that set them has retired. The execution pipe does not compute flags on every instruction. It saves a small operation code together with two 32-bit values: the source operand and the result. When software or a conditional branch needs the flags, this block is started with those saved values. It works out the flags from the result and the source alone, using a formula chosen by the operation code.

The supported operation classes are:

- logic operations;
- add and subtract;
- byte and word compares, which are evaluated only on the low 8 or 16 bits;
- add and subtract with extend;
- logical left and right shifts, and the arithmetic right shift, where the shift count sits in the source value.

A pass-through code means the result value already holds packed flags. In that case the value is returned as it is.

The packed flag word appears one clock after the start strobe, together with a one-cycle done pulse. With that same pulse the block signals one of two things:

- the saved state has now collapsed to pass-through, so the caller may store the flag word as its new result with the pass-through code;
- the code was not a legal one.

Top module: `lazy_cc_eval`

## Requirements
- R1: Every cycle in which `start` is high produces a `done` pulse in the following cycle, and `done` is low in any cycle not preceded by a start. `flagWord`, `illegalOp` and `collapsed` are valid in the cycle `done` is high. Back-to-back starts produce back-to-back results.
- R2: Operation codes are 0 pass-through, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-extend, 7 subtract-extend, 8 shift left, 9 logical shift right and 10 arithmetic shift right. For every code from 1 to 10 the flag word carries carry in bit 0, overflow in bit 1, zero in bit 2 and negative in bit 3, and all higher bits are zero.
- R3: For the arithmetic and logic codes, zero is set when `destVal` at the operation width is zero. Negative is set only when that value is nonzero and its sign bit is one, so zero and negative are never both set.
- R4: Logic (code 1) clears carry and overflow.
- R5: Add (code 2):
  - carry is `destVal < srcVal` (unsigned);
  - with t = `destVal` − `srcVal`, overflow is bit 31 of (`srcVal`^`destVal`) & ~(t^`srcVal`).
- R6: Subtract (code 3):
  - with t = `destVal` + `srcVal`, carry is t < `srcVal` (unsigned);
  - overflow is bit 31 of (t^`destVal`) & (t^`srcVal`).
- R7: Byte and word compares (codes 4, 5) apply the subtract rule to the low 8 or 16 bits only, with sign bit 7 or 15. The upper bits of both inputs have no effect.
- R8: Add-extend (code 6):
  - carry is `destVal <= srcVal` (unsigned);
  - overflow uses the add formula with t = `destVal` − `srcVal` − 1.
- R9: Subtract-extend (code 7):
  - with t = `destVal` + `srcVal` + 1, carry is t <= `srcVal` (unsigned);
  - overflow is bit 31 of (t^`destVal`) & (t^`srcVal`).
- R10: For the shifts (codes 8 to 10) the count is the whole of `srcVal`.
  - When the count is below 32, zero and negative reflect `destVal` shifted by the count.
  - When the count is 32 or more, they reflect zero for the logical shifts and all-ones for the arithmetic shift.
  - Overflow is 0 for all shifts.
- R11: A shift sets carry only for counts 1 to 32. Shift left then takes bit (32 − count) of `destVal`, and the right shifts take bit (count − 1).
- R12: Pass-through (code 0) returns `destVal` unchanged as the flag word. `collapsed` pulses with `done` for every legal code.
- R13: Codes 11 to 15 raise `illegalOp` with `done`, leave `collapsed` low and return a flag word of zero.
- R14: During and right after reset, `done`, `illegalOp`, `collapsed` and `flagWord` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the presented saved state this cycle |
| opCode | input | 4 | Saved operation code |
| srcVal | input | 32 | Saved source operand or shift count |
| destVal | input | 32 | Saved result, or packed flags in pass-through |
| flagWord | output | 32 | Packed flags (C bit 0, V bit 1, Z bit 2, N bit 3) |
| done | output | 1 | One-cycle result strobe |
| illegalOp | output | 1 | The operation code was not legal |
| collapsed | output | 1 | The saved state may be replaced by pass-through |

## Verification
The bench targets the following corner cases and the failure each would expose:

- **Compares with unequal upper bits.** Byte and word compares are driven with upper bits that disagree with the low bits. A design that evaluated at 32 bits would report the wrong sign, zero or overflow.
- **Extend forms at their boundaries.** Add-extend is driven with equal operands and subtract-extend with a zero source. A design that reused the plain add or subtract rule would lose the carry or the overflow there.
- **Shift counts.** Counts of 0, 31, 32 and above 32 are all driven. A design that masked the count to five bits would report the shifted value instead of the saturated zero or all-ones, and would drop the carry at a count of 32.
- **Opcode handling and timing.** Illegal codes, pass-through of arbitrary words, back-to-back starts and a lone pulse are all exercised. These catch misplaced strobes and stale flag words.

// File: rtl/lazy_cc_pkg.sv
package lazy_cc_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;
  localparam int FLAG_CNT = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PASS  = 4'd0,
    OP_LOGIC = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_CMPB  = 4'd4,
    OP_CMPW  = 4'd5,
    OP_ADDX  = 4'd6,
    OP_SUBX  = 4'd7,
    OP_SHL   = 4'd8,
    OP_SHR   = 4'd9,
    OP_SAR   = 4'd10
  } ccOpE;

  // formula family chosen by the control
  typedef enum logic [3:0] {
    FAM_PASS,
    FAM_LOGIC,
    FAM_ADD,
    FAM_SUB,
    FAM_ADDX,
    FAM_SUBX,
    FAM_SHL,
    FAM_SHR,
    FAM_SAR
  } famE;

  // operand width used by the subtract-style rule
  typedef enum logic [1:0] {
    SEL_BYTE = 2'd0,
    SEL_WORD = 2'd1,
    SEL_FULL = 2'd2
  } widthE;

  typedef struct packed {
    logic  load;
    logic  clear;
    famE   fam;
    widthE width;
  } ctrlStrobeT;

endpackage

// File: rtl/lazy_cc_subflags.sv
// Subtract-style flag rule evaluated at a fixed operand width.
module lazy_cc_subflags #(
  parameter int W      = 8,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] dIn,
  input  logic [DATA_W-1:0] sIn,
  output logic              cOut,
  output logic              vOut,
  output logic              nOut,
  output logic              zOut
);

  logic [W-1:0] dNarrow;
  logic [W-1:0] sNarrow;
  logic [W-1:0] sumNarrow;
  logic [W-1:0] ovfVec;

  always_comb begin
    dNarrow   = dIn[W-1:0];
    sNarrow   = sIn[W-1:0];
    sumNarrow = dNarrow + sNarrow;
    ovfVec    = (sumNarrow ^ dNarrow) & (sumNarrow ^ sNarrow);
    cOut      = sumNarrow < sNarrow;
    vOut      = ovfVec[W-1];
    zOut      = (dNarrow == '0);
    nOut      = !zOut && dNarrow[W-1];
  end

  // the high part of the inputs is deliberately ignored
  if (W < DATA_W) begin : g_unused
    logic unusedHigh;
    assign unusedHigh = ^{dIn[DATA_W-1:W], sIn[DATA_W-1:W]};
  end

endmodule

// File: rtl/lazy_cc_ctrl.sv
// Decodes the saved operation code and times the result strobes.
module lazy_cc_ctrl
  import lazy_cc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] opCode,
  output ctrlStrobeT      strobe,
  output logic            done,
  output logic            illegalOp,
  output logic            collapsed
);

  logic  legal;
  famE   famSel;
  widthE widthSel;

  always_comb begin
    legal    = 1'b1;
    famSel   = FAM_PASS;
    widthSel = SEL_FULL;
    case (opCode)
      OP_PASS:  famSel = FAM_PASS;
      OP_LOGIC: famSel = FAM_LOGIC;
      OP_ADD:   famSel = FAM_ADD;
      OP_SUB:   famSel = FAM_SUB;
      OP_CMPB: begin
        famSel   = FAM_SUB;
        widthSel = SEL_BYTE;
      end
      OP_CMPW: begin
        famSel   = FAM_SUB;
        widthSel = SEL_WORD;
      end
      OP_ADDX:  famSel = FAM_ADDX;
      OP_SUBX:  famSel = FAM_SUBX;
      OP_SHL:   famSel = FAM_SHL;
      OP_SHR:   famSel = FAM_SHR;
      OP_SAR:   famSel = FAM_SAR;
      default:  legal = 1'b0;
    endcase
  end

  always_comb begin
    strobe.load  = start && legal;
    strobe.clear = start && !legal;
    strobe.fam   = famSel;
    strobe.width = widthSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      illegalOp <= 1'b0;
      collapsed <= 1'b0;
    end else begin
      done      <= start;
      illegalOp <= start && !legal;
      collapsed <= start && legal;
    end
  end

endmodule

// File: rtl/lazy_cc_dpath.sv
// Rebuilds the flags from the saved result and source and registers them.
module lazy_cc_dpath
  import lazy_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] destVal,
  output logic [DATA_W-1:0] flagWord
);

  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int N_WIDTHS = 3;
  localparam logic [DATA_W-1:0]  DW_FULL  = DATA_W;
  localparam logic [SHAMT_W:0]   DW_SHORT = (SHAMT_W+1)'(DATA_W);
  localparam logic [SHAMT_W:0]   ONE_SHORT = (SHAMT_W+1)'(1);

  // subtract-rule units, one per operand width
  logic [N_WIDTHS-1:0] subC;
  logic [N_WIDTHS-1:0] subV;
  logic [N_WIDTHS-1:0] subN;
  logic [N_WIDTHS-1:0] subZ;

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
    localparam int GW = (g == 0) ? 8 : (g == 1) ? 16 : DATA_W;
    lazy_cc_subflags #(.W(GW), .DATA_W(DATA_W)) u_sub (
      .dIn (destVal),
      .sIn (srcVal),
      .cOut(subC[g]),
      .vOut(subV[g]),
      .nOut(subN[g]),
      .zOut(subZ[g])
    );
  end

  // full-width result sign/zero, shared by the dest-based families
  logic fullN;
  logic fullZ;
  assign fullN = subN[SEL_FULL];
  assign fullZ = subZ[SEL_FULL];

  // add and extend forms
  logic [DATA_W-1:0] addDiff;
  logic [DATA_W-1:0] addxDiff;
  logic [DATA_W-1:0] subxSum;
  logic              addV;
  logic              addxV;
  logic              subxV;
  logic [DATA_W-1:0] addVec;
  logic [DATA_W-1:0] addxVec;
  logic [DATA_W-1:0] subxVec;

  always_comb begin
    addDiff  = destVal - srcVal;
    addxDiff = destVal - srcVal - DATA_W'(1);
    subxSum  = destVal + srcVal + DATA_W'(1);
    addVec   = (srcVal ^ destVal) & ~(addDiff ^ srcVal);
    addxVec  = (srcVal ^ destVal) & ~(addxDiff ^ srcVal);
    subxVec  = (subxSum ^ destVal) & (subxSum ^ srcVal);
    addV     = addVec[DATA_W-1];
    addxV    = addxVec[DATA_W-1];
    subxV    = subxVec[DATA_W-1];
  end

  // shifts
  logic               cntBig;
  logic               cntCarry;
  logic [SHAMT_W:0]   cntShort;
  logic [SHAMT_W-1:0] shlBit;
  logic [SHAMT_W-1:0] shrBit;
  logic [DATA_W-1:0]  shlVal;
  logic [DATA_W-1:0]  shrVal;
  logic [DATA_W-1:0]  sarVal;
  logic               shlC;
  logic               shrC;

  always_comb begin
    cntBig   = srcVal >= DW_FULL;
    cntCarry = (srcVal != '0) && (srcVal <= DW_FULL);
    cntShort = srcVal[SHAMT_W:0];
    shlBit   = SHAMT_W'(DW_SHORT - cntShort);
    shrBit   = SHAMT_W'(cntShort - ONE_SHORT);
    shlVal   = cntBig ? '0 : destVal << cntShort[SHAMT_W-1:0];
    shrVal   = cntBig ? '0 : destVal >> cntShort[SHAMT_W-1:0];
    sarVal   = cntBig ? '1 : DATA_W'($signed(destVal) >>> cntShort[SHAMT_W-1:0]);
    shlC     = cntCarry && destVal[shlBit];
    shrC     = cntCarry && destVal[shrBit];
  end

  function automatic logic [1:0] signZero(input logic [DATA_W-1:0] v);
    logic z;
    z = (v == '0);
    return {!z && v[DATA_W-1], z};
  endfunction

  logic [1:0]          shlNz;
  logic [1:0]          shrNz;
  logic [1:0]          sarNz;
  logic [FLAG_CNT-1:0] nib;
  logic [DATA_W-1:0]   nextFlags;

  always_comb begin
    shlNz = signZero(shlVal);
    shrNz = signZero(shrVal);
    sarNz = signZero(sarVal);
    nib   = '0;
    case (strobe.fam)
      FAM_LOGIC: begin
        nib[FLAG_N] = fullN;
        nib[FLAG_Z] = fullZ;
      end
      FAM_ADD: begin
        nib[FLAG_N] = fullN;
        nib[FLAG_Z] = fullZ;
        nib[FLAG_C] = destVal < srcVal;
        nib[FLAG_V] = addV;
      end
      FAM_SUB: begin
        nib[FLAG_N] = subN[strobe.width];
        nib[FLAG_Z] = subZ[strobe.width];
        nib[FLAG_C] = subC[strobe.width];
        nib[FLAG_V] = subV[strobe.width];
      end
      FAM_ADDX: begin
        nib[FLAG_N] = fullN;
        nib[FLAG_Z] = fullZ;
        nib[FLAG_C] = destVal <= srcVal;
        nib[FLAG_V] = addxV;
      end
      FAM_SUBX: begin
        nib[FLAG_N] = fullN;
        nib[FLAG_Z] = fullZ;
        nib[FLAG_C] = subxSum <= srcVal;
        nib[FLAG_V] = subxV;
      end
      FAM_SHL: begin
        {nib[FLAG_N], nib[FLAG_Z]} = shlNz;
        nib[FLAG_C] = shlC;
      end
      FAM_SHR: begin
        {nib[FLAG_N], nib[FLAG_Z]} = shrNz;
        nib[FLAG_C] = shrC;
      end
      FAM_SAR: begin
        {nib[FLAG_N], nib[FLAG_Z]} = sarNz;
        nib[FLAG_C] = shrC;
      end
      default: nib = '0;
    endcase
    nextFlags = (strobe.fam == FAM_PASS) ? destVal : DATA_W'(nib);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagWord <= '0;
    end else if (strobe.clear) begin
      flagWord <= '0;
    end else if (strobe.load) begin
      flagWord <= nextFlags;
    end
  end

endmodule

// File: rtl/lazy_cc_eval.sv
module lazy_cc_eval
  import lazy_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] destVal,
  output logic [DATA_W-1:0] flagWord,
  output logic              done,
  output logic              illegalOp,
  output logic              collapsed
);

  ctrlStrobeT strobe;

  lazy_cc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opCode   (opCode),
    .strobe   (strobe),
    .done     (done),
    .illegalOp(illegalOp),
    .collapsed(collapsed)
  );

  lazy_cc_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcVal  (srcVal),
    .destVal (destVal),
    .flagWord(flagWord)
  );

endmodule

// File: rtl/lazy_cc_eval_chk.sv
module lazy_cc_eval_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] destVal,
  input logic [DATA_W-1:0] flagWord,
  input logic              done,
  input logic              illegalOp,
  input logic              collapsed
);

  p_done_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  p_done_caused_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));

  p_packed_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode != 4'd0 && opCode <= 4'd10) |=> (flagWord[DATA_W-1:4] == '0));

  p_nz_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode != 4'd0 && opCode <= 4'd10) |=> !(flagWord[2] && flagWord[3]));

  p_logic_no_cv_r4: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode == 4'd1) |=> (flagWord[1:0] == 2'b00));

  p_pass_copy_r12: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode == 4'd0) |=> (flagWord == $past(destVal) && collapsed));

  p_collapse_with_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    collapsed |-> done);

  p_illegal_clean_r13: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (done && !collapsed && flagWord == '0));

endmodule

bind lazy_cc_eval lazy_cc_eval_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .opCode   (opCode),
  .destVal  (destVal),
  .flagWord (flagWord),
  .done     (done),
  .illegalOp(illegalOp),
  .collapsed(collapsed)
);

// File: tb/lazy_cc_eval_tb.sv
module lazy_cc_eval_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] destVal = '0;
  logic [31:0] flagWord;
  logic        done;
  logic        illegalOp;
  logic        collapsed;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lazy_cc_eval u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .srcVal(srcVal), .destVal(destVal), .flagWord(flagWord),
    .done(done), .illegalOp(illegalOp), .collapsed(collapsed)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] src;
    logic [31:0] dest;
    logic [31:0] exp;
    logic [7:0]  req;
  } vecT;

  localparam int NV = 28;
  localparam vecT VECS [NV] = '{
    '{4'd1,  32'h0,        32'h0,        32'h4,        8'd3},  // R3 logic zero
    '{4'd1,  32'h0,        32'h80000000, 32'h8,        8'd3},  // R3 logic negative
    '{4'd1,  32'hFFFFFFFF, 32'h1,        32'h0,        8'd4},  // R4 logic C/V clear
    '{4'd2,  32'h2,        32'h1,        32'h1,        8'd5},  // R5 add carry
    '{4'd2,  32'h1,        32'h80000000, 32'hA,        8'd5},  // R5 add overflow
    '{4'd3,  32'h7,        32'hFFFFFFFE, 32'h9,        8'd6},  // R6 sub borrow
    '{4'd3,  32'h1,        32'h7FFFFFFF, 32'h2,        8'd6},  // R6 sub overflow
    '{4'd3,  32'h5,        32'h0,        32'h4,        8'd6},  // R6 sub zero
    '{4'd4,  32'h12345610, 32'hFFFFFF00, 32'h4,        8'd7},  // R7 byte zero, upper junk
    '{4'd4,  32'h1,        32'h7F,       32'h2,        8'd7},  // R7 byte overflow
    '{4'd5,  32'h1,        32'h0000FFFF, 32'h9,        8'd7},  // R7 word N and C
    '{4'd5,  32'h0,        32'hABCD0000, 32'h4,        8'd7},  // R7 word zero, upper junk
    '{4'd6,  32'h5,        32'h5,        32'h1,        8'd8},  // R8 addx equal -> carry
    '{4'd6,  32'h7FFFFFFF, 32'h80000000, 32'hA,        8'd8},  // R8 addx overflow
    '{4'd7,  32'h0,        32'hFFFFFFFF, 32'h9,        8'd9},  // R9 subx carry
    '{4'd7,  32'h0,        32'h7FFFFFFF, 32'h2,        8'd9},  // R9 subx overflow
    '{4'd8,  32'd1,        32'h80000001, 32'h1,        8'd11}, // R11 shl carry
    '{4'd8,  32'd0,        32'h80000000, 32'h8,        8'd11}, // R11 count 0 no carry
    '{4'd8,  32'd32,       32'h00000001, 32'h5,        8'd10}, // R10 shl 32
    '{4'd8,  32'd33,       32'hFFFFFFFF, 32'h4,        8'd10}, // R10 shl 33
    '{4'd9,  32'd1,        32'h00000003, 32'h1,        8'd11}, // R11 shr carry
    '{4'd9,  32'd32,       32'h80000000, 32'h5,        8'd10}, // R10 shr 32
    '{4'd9,  32'd31,       32'h40000000, 32'h5,        8'd11}, // R11 shr 31
    '{4'd10, 32'd4,        32'h80000000, 32'h8,        8'd10}, // R10 sar
    '{4'd10, 32'd40,       32'h00000000, 32'h8,        8'd10}, // R10 sar big -> ones
    '{4'd10, 32'd32,       32'h80000000, 32'h9,        8'd11}, // R11 sar 32
    '{4'd0,  32'h0,        32'h0000001F, 32'h1F,       8'd12}, // R12 pass
    '{4'd0,  32'h12345678, 32'hDEADBEEF, 32'hDEADBEEF, 8'd12}  // R12 pass
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (after one rising edge)
  task automatic apply(input logic [3:0] op, input logic [31:0] s, input logic [31:0] d);
    @(negedge clk);
    opCode = op; srcVal = s; destVal = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    chk("R14 done", 32'(done), 32'h0);
    chk("R14 flagWord", flagWord, 32'h0);
    chk("R14 illegal/collapsed", {30'h0, illegalOp, collapsed}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R14 after release", {29'h0, done, illegalOp, collapsed}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].src, VECS[i].dest);
      chk($sformatf("R%0d vector %0d flags", VECS[i].req, i), flagWord, VECS[i].exp);
      chk($sformatf("R1/R12 vector %0d strobes", i), {29'h0, done, illegalOp, collapsed}, 32'h5);
    end

    // R1: lone pulse, done falls the cycle after
    @(negedge clk);
    chk("R1 done one cycle", 32'(done), 32'h0);

    // R13 illegal codes after a nonzero result
    apply(4'd0, 32'h0, 32'hFFFFFFFF);
    apply(4'd11, 32'h1, 32'h1);
    chk("R13 code 11 flags", flagWord, 32'h0);
    chk("R13 code 11 strobes", {29'h0, done, illegalOp, collapsed}, 32'h6);
    apply(4'd15, 32'h0, 32'h0);
    chk("R13 code 15 strobes", {29'h0, done, illegalOp, collapsed}, 32'h6);
    apply(4'd1, 32'h0, 32'h0);
    chk("R13 recovers legal", {29'h0, done, illegalOp, collapsed}, 32'h5);

    // R1 back-to-back starts
    @(negedge clk);
    opCode = 4'd2; srcVal = 32'h2; destVal = 32'h1; start = 1'b1;
    @(negedge clk);
    chk("R1 first of pair", flagWord, 32'h1);
    chk("R1 first done", 32'(done), 32'h1);
    opCode = 4'd3; srcVal = 32'h5; destVal = 32'h0;
    @(negedge clk);
    start = 1'b0;
    chk("R1 second of pair", flagWord, 32'h4);
    chk("R1 second done", 32'(done), 32'h1);
    @(negedge clk);
    chk("R1 done drops", 32'(done), 32'h0);
    chk("R1 flags held", flagWord, 32'h4);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule